// File: doc/BRIEF.md
# Transmit Pause Countdown Gate

This block holds the remaining pause time that a full-duplex link partner has asked for and uses it to stop the transmitter. A receive path that has recognised a valid pause request presents a 16-bit quantum with a one-cycle load strobe. From the next cycle on, `tx_hold` tells the transmit scheduler not to start another frame. A frame already on the wire, shown by `tx_busy`, is allowed to finish. The countdown only runs while no frame is in flight.

Each quantum unit lasts 512 bit times. The datapath moves 8 bits per transmit clock, so one unit is 64 clocks. A test input makes every idle clock count as one unit, so short runs can cover long pause times. A new quantum replaces the current one at any time, and the slot prescaler restarts when it does. When a decrement takes the count to zero, the hold is released and a single-cycle pulse is raised if that event is enabled. A zero quantum releases the hold at once and raises no pulse. The whole function is switched by a receive-pause enable. While that enable is low, loads are ignored and any pending pause is dropped.

Top module: `txpause_gate`

## Requirements
- R1: A load with `pause_en` high and a non-zero `load_quanta` drives `tx_hold` high from the next clock. `tx_hold` is high exactly while the held quantum is non-zero.
- R2: No decrement happens in any cycle in which `tx_busy` is high. Counting starts or resumes in the first cycle after `tx_busy` falls.
- R3: With `test_fast` low, the quantum decrements once every 64 idle clocks (512 bit times at 8 bits per clock). An uninterrupted quantum Q keeps `tx_hold` high for exactly 64*Q clocks after the load.
- R4: With `test_fast` high, the quantum decrements on every idle clock. An uninterrupted quantum Q keeps `tx_hold` high for exactly Q clocks after the load.
- R5: A load during a countdown replaces the remaining count with the new value. It also restarts the 64-clock slot, so the next decrement comes a full slot after the reload.
- R6: When a decrement takes the count from 1 to 0, `zero_pulse` is high for exactly one clock, in the same cycle that `tx_hold` first reads low. This happens only if `zero_irq_en` was high on the edge of that decrement. With the enable low, no pulse appears.
- R7: Loading a zero quantum drops `tx_hold` from the next clock, both from idle and in the middle of a countdown, and never produces `zero_pulse`.
- R8: While `pause_en` is low, loads have no effect and `tx_hold` stays low. Dropping `pause_en` during a countdown clears the held quantum, so `tx_hold` is low from the next clock, with no `zero_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| pause_en | input | 1 | Receive-pause enable; low clears and ignores quanta |
| test_fast | input | 1 | Test mode: one decrement per idle clock |
| load_strb | input | 1 | One-cycle strobe: new pause quantum present |
| load_quanta | input | 16 | Pause quantum, in units of 512 bit times |
| tx_busy | input | 1 | High while a frame is being transmitted |
| zero_irq_en | input | 1 | Enables the count-reached-zero pulse |
| tx_hold | output | 1 | High: no new frame may start |
| zero_pulse | output | 1 | One-cycle pulse when a decrement reaches zero |

## Verification
The bench measures hold length in clocks. A design that counted during a busy frame would release the hold early by the length of the busy window. A design that kept the prescaler phase across a reload would cut the first slot after the reload short: 128 clocks instead of 164 in the directed case. Reloads to zero, both from idle and mid-countdown, are checked for the absence of `zero_pulse`. This catches a design that treats any drop to zero as the decrement event. Dropping `pause_en` mid-countdown, and loading while it is low, show whether stale quanta survive. Counting exactly one pulse per countdown, and matching its cycle to the hold release, catches a pulse that is stretched, misplaced or left ungated.

// File: rtl/txpause_pkg.sv
package txpause_pkg;

  // Number of transmit clocks in one pause slot.
  function automatic int slot_clocks(input int slot_bits, input int bits_per_clk);
    return (slot_bits + bits_per_clk - 1) / bits_per_clk;
  endfunction

  // Phase register width, at least one bit.
  function automatic int phase_width(input int div);
    return (div > 1) ? $clog2(div) : 1;
  endfunction

  // True when the slot phase sits on its last clock.
  function automatic bit slot_last(input int phase, input int div);
    return phase == (div - 1);
  endfunction

  // Next slot phase; wraps to zero after the last clock.
  function automatic int slot_advance(input int phase, input int div);
    return slot_last(phase, div) ? 0 : phase + 1;
  endfunction

endpackage

// File: rtl/txpause_slot_timer.sv
module txpause_slot_timer
  import txpause_pkg::*;
#(
  parameter int DIV = 64,
  localparam int PW = phase_width(DIV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          fast,
  output logic          tick,
  output logic [PW-1:0] phase
);

  logic [PW-1:0] phase_q;
  logic          at_last;

  assign at_last = slot_last(int'(phase_q), DIV);
  assign tick    = run && (fast || at_last);
  assign phase   = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (run) begin
      if (fast) phase_q <= '0;
      else      phase_q <= PW'(slot_advance(int'(phase_q), DIV));
    end
  end

endmodule

// File: rtl/txpause_quanta_reg.sv
module txpause_quanta_reg #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          load,
  input  logic [QW-1:0] load_val,
  input  logic          step,
  input  logic          irq_en,
  output logic [QW-1:0] quanta,
  output logic          zero_evt,
  output logic          zero_pulse
);

  logic [QW-1:0] cnt_q;
  logic          pulse_q;
  logic          nonzero;

  assign nonzero    = (cnt_q != '0);
  assign zero_evt   = enable && !load && step && (cnt_q == QW'(1));
  assign quanta     = cnt_q;
  assign zero_pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= zero_evt && irq_en;
      if (!enable)              cnt_q <= '0;
      else if (load)            cnt_q <= load_val;
      else if (step && nonzero) cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/txpause_gate.sv
module txpause_gate
  import txpause_pkg::*;
#(
  parameter int QW           = 16,
  parameter int SLOT_BITS    = 512,
  parameter int BITS_PER_CLK = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pause_en,
  input  logic          test_fast,
  input  logic          load_strb,
  input  logic [QW-1:0] load_quanta,
  input  logic          tx_busy,
  input  logic          zero_irq_en,
  output logic          tx_hold,
  output logic          zero_pulse
);

  localparam int SLOT_DIV = slot_clocks(SLOT_BITS, BITS_PER_CLK);
  localparam int PW       = phase_width(SLOT_DIV);

  logic [QW-1:0] quanta_q;
  logic [PW-1:0] slot_phase;
  logic          slot_tick;
  logic          slot_run;
  logic          slot_restart;
  logic          load_take;
  logic          zero_evt;

  assign load_take    = pause_en && load_strb;
  assign slot_restart = load_strb || !pause_en;
  assign slot_run     = pause_en && !load_strb && !tx_busy && (quanta_q != '0);

  txpause_slot_timer #(.DIV(SLOT_DIV)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (slot_restart),
    .run     (slot_run),
    .fast    (test_fast),
    .tick    (slot_tick),
    .phase   (slot_phase)
  );

  txpause_quanta_reg #(.QW(QW)) u_quanta (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (pause_en),
    .load       (load_take),
    .load_val   (load_quanta),
    .step       (slot_tick),
    .irq_en     (zero_irq_en),
    .quanta     (quanta_q),
    .zero_evt   (zero_evt),
    .zero_pulse (zero_pulse)
  );

  assign tx_hold = (quanta_q != '0);

endmodule

// File: rtl/txpause_gate_chk.sv
module txpause_gate_chk #(
  parameter int QW  = 16,
  parameter int DIV = 64,
  parameter int PW  = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pause_en,
  input logic          test_fast,
  input logic          load_strb,
  input logic [QW-1:0] load_quanta,
  input logic          tx_busy,
  input logic          zero_irq_en,
  input logic          tx_hold,
  input logic          zero_pulse,
  input logic [QW-1:0] quanta,
  input logic [PW-1:0] slot_phase,
  input logic          zero_evt
);

  a_r1_hold_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && load_strb && load_quanta != '0) |=> tx_hold);

  a_r2_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && !load_strb && tx_busy) |=> $stable(quanta));

  a_r3_slot_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && !load_strb && !test_fast && slot_phase != PW'(DIV - 1)) |=> $stable(quanta));

  a_r4_fast_step: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && !load_strb && test_fast && !tx_busy && quanta != '0)
      |=> (quanta == $past(quanta) - 1'b1));

  a_r5_load_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && load_strb) |=> (quanta == $past(load_quanta)));

  a_r6_pulse_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |-> (quanta == '0 && $past(quanta) == QW'(1) && $past(zero_irq_en)));

  a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    zero_pulse |=> !zero_pulse);

  a_r6_event_is_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> (quanta == '0));

  a_r7_zero_load_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_en && load_strb && load_quanta == '0) |=> (!tx_hold && !zero_pulse));

  a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_en |=> (!tx_hold && !zero_pulse));

endmodule

bind txpause_gate txpause_gate_chk #(.QW(QW), .DIV(SLOT_DIV), .PW(PW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pause_en    (pause_en),
  .test_fast   (test_fast),
  .load_strb   (load_strb),
  .load_quanta (load_quanta),
  .tx_busy     (tx_busy),
  .zero_irq_en (zero_irq_en),
  .tx_hold     (tx_hold),
  .zero_pulse  (zero_pulse),
  .quanta      (quanta_q),
  .slot_phase  (slot_phase),
  .zero_evt    (zero_evt)
);

// File: tb/txpause_gate_tb.sv
`timescale 1ns/1ps
module txpause_gate_tb;

  localparam int SLOT = 512 / 8;   // clocks per quantum in normal mode

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pause_en = 1'b0;
  logic        test_fast = 1'b0;
  logic        load_strb = 1'b0;
  logic [15:0] load_quanta = '0;
  logic        tx_busy = 1'b0;
  logic        zero_irq_en = 1'b0;
  logic        tx_hold;
  logic        zero_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  txpause_gate u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .pause_en    (pause_en),
    .test_fast   (test_fast),
    .load_strb   (load_strb),
    .load_quanta (load_quanta),
    .tx_busy     (tx_busy),
    .zero_irq_en (zero_irq_en),
    .tx_hold     (tx_hold),
    .zero_pulse  (zero_pulse)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Loads q, optionally holds tx_busy for busy_n clocks, optionally reloads q2
  // at index reload_at, then returns the hold length and pulse count.
  task automatic run_case(input logic [15:0] q, input bit fast, input int busy_n,
                          input int reload_at, input logic [15:0] q2, input bit irq,
                          output int len, output int pulses);
    int n = 0;
    pulses = 0;
    @(negedge clk);
    test_fast = fast; zero_irq_en = irq; pause_en = 1'b1;
    tx_busy = (busy_n > 0);
    load_strb = 1'b1; load_quanta = q;
    @(negedge clk);
    load_strb = 1'b0;
    while (tx_hold && n < 100000) begin
      if (n == busy_n) tx_busy = 1'b0;
      if (n == reload_at) begin load_strb = 1'b1; load_quanta = q2; end
      else load_strb = 1'b0;
      if (zero_pulse) pulses++;
      n++;
      @(negedge clk);
    end
    load_strb = 1'b0; tx_busy = 1'b0;
    if (zero_pulse) pulses++;
    @(negedge clk);
    if (zero_pulse) pulses++;
    len = n;
  endtask

  task automatic t_reset();
    check("R1", "hold after reset", int'(tx_hold), 0);
    check("R6", "pulse after reset", int'(zero_pulse), 0);
  endtask

  task automatic t_fast_basic();
    int len, p;
    run_case(16'd37, 1'b1, 0, -1, 16'd0, 1'b1, len, p);
    check("R4", "fast hold length q=37", len, 37);
    check("R6", "pulse count fast", p, 1);
  endtask

  task automatic t_fast_irq_off();
    int len, p;
    run_case(16'd5, 1'b1, 0, -1, 16'd0, 1'b0, len, p);
    check("R4", "fast hold length q=5", len, 5);
    check("R6", "no pulse with enable low", p, 0);
  endtask

  task automatic t_normal();
    int len, p;
    run_case(16'd3, 1'b0, 0, -1, 16'd0, 1'b1, len, p);
    check("R3", "normal hold length q=3", len, 3 * SLOT);
    check("R6", "pulse count normal", p, 1);
  endtask

  task automatic t_busy_wait();
    int len, p;
    run_case(16'd8, 1'b1, 13, -1, 16'd0, 1'b1, len, p);
    check("R2", "fast hold with 13 busy clocks", len, 13 + 8);
    run_case(16'd1, 1'b0, 40, -1, 16'd0, 1'b1, len, p);
    check("R2", "normal hold with 40 busy clocks", len, 40 + SLOT);
    check("R6", "pulse after busy wait", p, 1);
  endtask

  task automatic t_reload();
    int len, p;
    run_case(16'd10, 1'b1, 0, 3, 16'd20, 1'b1, len, p);
    check("R5", "fast reload mid-count", len, 4 + 20);
    check("R6", "single pulse after reload", p, 1);
    run_case(16'd2, 1'b0, 0, 99, 16'd1, 1'b1, len, p);
    check("R5", "normal reload restarts slot", len, 100 + SLOT);
  endtask

  task automatic t_zero_load();
    int len, p;
    run_case(16'd50, 1'b1, 0, 2, 16'd0, 1'b1, len, p);
    check("R7", "zero reload mid-count length", len, 3);
    check("R7", "zero reload pulse", p, 0);
    run_case(16'd0, 1'b0, 0, -1, 16'd0, 1'b1, len, p);
    check("R7", "zero load from idle length", len, 0);
    check("R7", "zero load from idle pulse", p, 0);
  endtask

  task automatic t_disable();
    int seen = 0;
    int p = 0;
    @(negedge clk);
    pause_en = 1'b0; test_fast = 1'b1; zero_irq_en = 1'b1;
    load_strb = 1'b1; load_quanta = 16'd9;
    @(negedge clk);
    load_strb = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (tx_hold) seen++;
      if (zero_pulse) p++;
      @(negedge clk);
    end
    check("R8", "hold cycles after disabled load", seen, 0);
    pause_en = 1'b1;
    load_strb = 1'b1; load_quanta = 16'd40;
    @(negedge clk);
    load_strb = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1", "hold mid-count before disable", int'(tx_hold), 1);
    pause_en = 1'b0;
    @(negedge clk);
    check("R8", "hold one clock after disable", int'(tx_hold), 0);
    for (int i = 0; i < 45; i++) begin
      if (zero_pulse) p++;
      @(negedge clk);
    end
    check("R8", "pulses after disable", p, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fast_basic();
    t_fast_irq_off();
    t_normal();
    t_busy_wait();
    t_reload();
    t_zero_load();
    t_disable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule